// File: doc/BRIEF.md
# Multi-Block DMA Descriptor Sequencer

This unit is the control part of one DMA channel. It walks a transfer made of one or more blocks. It presents the parameters of the current block to the data mover: source address, destination address, control word and next-descriptor pointer. When the data mover reports a finished block, the unit either ends the transfer or loads the parameters of the next block. The data movement itself and arbitration between channels are outside this unit.

Each register group has its own reload method, chosen in a per-channel mode register. The method is applied between blocks:

- **Linked list.** The group takes its value from a four-word descriptor read from memory.
- **Auto-reload.** The group returns to the value it held when the channel was started.
- **Contiguous.** The group continues from where the previous block ended. Only the two address groups offer this method.

The next-descriptor pointer changes only through a descriptor fetch.

States: `SEQ_IDLE` (programmable, waiting for `start`), `SEQ_XFER` (block active), `SEQ_FETCH` (reading the descriptor), `SEQ_LOAD` (one cycle that applies the reload), `SEQ_DONE` (one cycle completion pulse). Transitions:

| From | To | Condition |
|---|---|---|
| IDLE | XFER | `start` |
| XFER | DONE | `blk_done` and chain end |
| XFER | FETCH | `blk_done`, no chain end, some group in linked-list mode |
| XFER | LOAD | `blk_done`, no chain end, no linked-list group |
| FETCH | LOAD | `rd_valid` on the fourth word |
| LOAD | XFER | always |
| DONE | IDLE | always |

Top module: `dma_desc_seq`

## Requirements
- R1: After reset the state is idle, and `blk_active`, `xfer_done` and `rd_req` are 0.
- R2: A `start` pulse in idle saves the programmed source, destination and control values as the auto-reload values. From the next cycle, `blk_active` is 1 and the programmed values appear on the block outputs.
- R3: The `cfg_wdata` written with `cfg_we` goes to the register chosen by `cfg_sel`: 0 source, 1 destination, 2 next pointer, 3 control, 4 mode. Writes are taken only in idle; while a block is active they leave the outputs unchanged.
- R4: A descriptor fetch holds `rd_req` with `rd_addr` stable until `rd_valid`. It reads four words at the pointer, pointer+4, pointer+8 and pointer+12.
- R5: The descriptor words are, in order: source address, destination address, next pointer, control word. Each address or control group in linked-list mode takes its word, and the next pointer always takes word 2 after a fetch.
- R6: Auto-reload mode restores the value the group held at `start`.
- R7: Contiguous mode sets the address to the previous block's address plus length × 2^width. The length is control bits [11:0] and the width code is control bits [13:12].
- R8: The mode register holds the source mode in bits [1:0], the destination mode in bits [3:2] and the control mode in bits [5:4]. The codes are 0 contiguous, 1 auto-reload and 2 linked list. Code 0 for the control group acts as auto-reload.
- R9: On `blk_done`, the chain ends if control bit 31 (last block) is 1. It also ends if some group is in linked-list mode and the next pointer is 0. At chain end, `xfer_done` is 1 for exactly one cycle, `blk_active` is 0 and the unit returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | DW | Register write data |
| start | input | 1 | Start the transfer (channel enable) |
| blk_done | input | 1 | Data mover finished the current block |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | DW | Descriptor read byte address |
| rd_valid | input | 1 | Read data valid, completes a read |
| rd_data | input | DW | Read data |
| blk_src | output | DW | Current source address |
| blk_dst | output | DW | Current destination address |
| blk_ctl | output | DW | Current control word |
| blk_next | output | DW | Current next-descriptor pointer |
| blk_active | output | 1 | Block parameters valid, block in progress |
| xfer_done | output | 1 | One-cycle transfer-complete pulse |

## Verification
The second-block parameters are checked across several mixes of per-group modes:

- All linked-list, all auto-reload and all contiguous.
- Contiguous source with list-fetched destination and control.
- Auto-reload source beside a contiguous destination.

These mixes tell apart a wrong mode-field decode, a wrong descriptor word order, and a contiguous step taken with the wrong width or from the wrong base.

Control-mode code 0 is tried to confirm that it acts as auto-reload. Two directed cases end the chain, one through the last-block flag and one through a zero pointer in a fetched descriptor. Another case writes a register while a block is active. The memory model inserts wait cycles so that the request-hold behaviour is exercised.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    typedef enum logic [1:0] {
        RL_CONTIG = 2'd0,
        RL_AUTO   = 2'd1,
        RL_LIST   = 2'd2
    } reload_e;

    typedef enum logic [2:0] {
        SEQ_IDLE  = 3'd0,
        SEQ_XFER  = 3'd1,
        SEQ_FETCH = 3'd2,
        SEQ_LOAD  = 3'd3,
        SEQ_DONE  = 3'd4
    } seq_state_e;

    localparam int unsigned DESC_WORDS = 4;
    localparam int unsigned SEL_SRC = 0;
    localparam int unsigned SEL_DST = 1;
    localparam int unsigned SEL_NXT = 2;
    localparam int unsigned SEL_CTL = 3;
    localparam int unsigned SEL_CFG = 4;
endpackage

// File: rtl/dma_addr_next.sv
module dma_addr_next
    import dma_seq_pkg::*;
#(
    parameter int unsigned DW    = 32,
    parameter int unsigned LEN_W = 12
) (
    input  logic [1:0]       mode,
    input  logic [DW-1:0]    cur,
    input  logic [DW-1:0]    init,
    input  logic [DW-1:0]    fetched,
    input  logic [LEN_W-1:0] len,
    input  logic [1:0]       wcode,
    output logic [DW-1:0]    nxt
);
    logic [DW-1:0] step;

    always_comb begin
        step = DW'(len) << wcode;
        case (mode)
            RL_LIST: nxt = fetched;
            RL_AUTO: nxt = init;
            default: nxt = cur + step;
        endcase
    end
endmodule

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch
    import dma_seq_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       go,
    input  logic [DW-1:0]              base,
    input  logic                       rd_valid,
    input  logic [DW-1:0]              rd_data,
    output logic                       rd_req,
    output logic [DW-1:0]              rd_addr,
    output logic                       last_beat,
    output logic [DESC_WORDS-1:0][DW-1:0] words
);
    localparam int unsigned IDX_W = $clog2(DESC_WORDS);

    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (!go) begin
            idx <= '0;
        end else if (rd_valid) begin
            idx <= idx + 1'b1;
        end
    end

    for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (go && rd_valid && idx == IDX_W'(g)) begin
                words[g] <= rd_data;
            end
        end
    end

    always_comb begin
        rd_req    = go;
        rd_addr   = base + (DW'(idx) << 2);
        last_beat = go && rd_valid && (idx == IDX_W'(DESC_WORDS - 1));
    end
endmodule

// File: rtl/dma_desc_seq.sv
module dma_desc_seq
    import dma_seq_pkg::*;
#(
    parameter int unsigned DW    = 32,
    parameter int unsigned LEN_W = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          start,
    input  logic          blk_done,
    output logic          rd_req,
    output logic [DW-1:0] rd_addr,
    input  logic          rd_valid,
    input  logic [DW-1:0] rd_data,
    output logic [DW-1:0] blk_src,
    output logic [DW-1:0] blk_dst,
    output logic [DW-1:0] blk_ctl,
    output logic [DW-1:0] blk_next,
    output logic          blk_active,
    output logic          xfer_done
);
    localparam int unsigned WC_LSB = LEN_W;
    localparam int unsigned LAST_B = DW - 1;

    seq_state_e state, state_nx;

    logic [DW-1:0] cur_src, cur_dst, cur_ctl, cur_nxt;
    logic [DW-1:0] init_src, init_dst, init_ctl;
    logic [5:0]    mode_q;
    logic [1:0]    src_mode, dst_mode, ctl_mode;
    logic          uses_list, chain_end, last_beat;
    logic [DW-1:0] nx_src, nx_dst, nx_ctl;
    logic [DESC_WORDS-1:0][DW-1:0] dwords;

    assign src_mode  = mode_q[1:0];
    assign dst_mode  = mode_q[3:2];
    assign ctl_mode  = mode_q[5:4];
    assign uses_list = (src_mode == RL_LIST) || (dst_mode == RL_LIST) ||
                       (ctl_mode == RL_LIST);
    assign chain_end = cur_ctl[LAST_B] || (uses_list && cur_nxt == '0);

    dma_desc_fetch #(.DW(DW)) fetch_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (state == SEQ_FETCH),
        .base      (cur_nxt),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .last_beat (last_beat),
        .words     (dwords)
    );

    dma_addr_next #(.DW(DW), .LEN_W(LEN_W)) src_next_i (
        .mode    (src_mode),
        .cur     (cur_src),
        .init    (init_src),
        .fetched (dwords[0]),
        .len     (cur_ctl[LEN_W-1:0]),
        .wcode   (cur_ctl[WC_LSB+1:WC_LSB]),
        .nxt     (nx_src)
    );

    dma_addr_next #(.DW(DW), .LEN_W(LEN_W)) dst_next_i (
        .mode    (dst_mode),
        .cur     (cur_dst),
        .init    (init_dst),
        .fetched (dwords[1]),
        .len     (cur_ctl[LEN_W-1:0]),
        .wcode   (cur_ctl[WC_LSB+1:WC_LSB]),
        .nxt     (nx_dst)
    );

    assign nx_ctl = (ctl_mode == RL_LIST) ? dwords[3] : init_ctl;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE:  if (start) state_nx = SEQ_XFER;
            SEQ_XFER:  if (blk_done) begin
                           if (chain_end)      state_nx = SEQ_DONE;
                           else if (uses_list) state_nx = SEQ_FETCH;
                           else                state_nx = SEQ_LOAD;
                       end
            SEQ_FETCH: if (last_beat) state_nx = SEQ_LOAD;
            SEQ_LOAD:  state_nx = SEQ_XFER;
            SEQ_DONE:  state_nx = SEQ_IDLE;
            default:   state_nx = SEQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        blk_active = (state == SEQ_XFER);
        xfer_done  = (state == SEQ_DONE);
        blk_src    = cur_src;
        blk_dst    = cur_dst;
        blk_ctl    = cur_ctl;
        blk_next   = cur_nxt;
    end

    // block parameter registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_src  <= '0;
            cur_dst  <= '0;
            cur_ctl  <= '0;
            cur_nxt  <= '0;
            init_src <= '0;
            init_dst <= '0;
            init_ctl <= '0;
            mode_q   <= '0;
        end else if (state == SEQ_IDLE) begin
            if (cfg_we) begin
                unique case (cfg_sel)
                    3'(SEL_SRC): cur_src <= cfg_wdata;
                    3'(SEL_DST): cur_dst <= cfg_wdata;
                    3'(SEL_NXT): cur_nxt <= cfg_wdata;
                    3'(SEL_CTL): cur_ctl <= cfg_wdata;
                    3'(SEL_CFG): mode_q  <= cfg_wdata[5:0];
                    default: ;
                endcase
            end
            if (start) begin
                init_src <= cur_src;
                init_dst <= cur_dst;
                init_ctl <= cur_ctl;
            end
        end else if (state == SEQ_LOAD) begin
            cur_src <= nx_src;
            cur_dst <= nx_dst;
            cur_ctl <= nx_ctl;
            if (uses_list) cur_nxt <= dwords[2];
        end
    end
endmodule

// File: rtl/dma_desc_seq_chk.sv
module dma_desc_seq_chk #(
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          blk_done,
    input logic          rd_req,
    input logic [DW-1:0] rd_addr,
    input logic          rd_valid,
    input logic [DW-1:0] blk_src,
    input logic [DW-1:0] blk_dst,
    input logic [DW-1:0] blk_ctl,
    input logic [DW-1:0] blk_next,
    input logic          blk_active,
    input logic          xfer_done
);
    logic [1:0] beats;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             beats <= '0;
        else if (!rd_req)       beats <= '0;
        else if (rd_valid)      beats <= beats + 1'b1;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done); // R9
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (!blk_active && !rd_req)); // R9
    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr))); // R4
    AST_FETCH_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req) |-> (rd_addr == blk_next)); // R4
    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_valid && beats != 2'd3) |=>
            (rd_req && rd_addr == $past(rd_addr) + DW'(4))); // R4
    AST_PARAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_active && !blk_done) |=>
            ($stable(blk_src) && $stable(blk_dst) && $stable(blk_ctl))); // R3
endmodule

bind dma_desc_seq dma_desc_seq_chk #(.DW(DW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .blk_done   (blk_done),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_valid   (rd_valid),
    .blk_src    (blk_src),
    .blk_dst    (blk_dst),
    .blk_ctl    (blk_ctl),
    .blk_next   (blk_next),
    .blk_active (blk_active),
    .xfer_done  (xfer_done)
);

// File: tb/dma_desc_seq_tb.sv
module dma_desc_seq_tb_top;
    localparam int unsigned DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic          start = 1'b0;
    logic          blk_done = 1'b0;
    logic          rd_req;
    logic [DW-1:0] rd_addr;
    logic          rd_valid = 1'b0;
    logic [DW-1:0] rd_data = '0;
    logic [DW-1:0] blk_src, blk_dst, blk_ctl, blk_next;
    logic          blk_active, xfer_done;

    int checks = 0;
    int errors = 0;
    logic stall = 1'b0;
    logic [DW-1:0] mem [0:3];
    logic [DW-1:0] log_addr [0:7];
    int nlog = 0;

    always #2 clk = ~clk;

    dma_desc_seq #(.DW(DW), .LEN_W(12)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start(start), .blk_done(blk_done),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .blk_src(blk_src), .blk_dst(blk_dst),
        .blk_ctl(blk_ctl), .blk_next(blk_next), .blk_active(blk_active),
        .xfer_done(xfer_done)
    );

    // descriptor memory at 0x100 with wait cycles on alternate beats
    initial begin
        mem[0] = 32'h0000_A000;
        mem[1] = 32'h0000_B000;
        mem[2] = 32'h0000_0000;
        mem[3] = 32'h0000_0010;
        forever begin
            @(negedge clk);
            if (rd_req && !stall) begin
                rd_valid = 1'b1;
                rd_data  = mem[rd_addr[3:2]];
                if (nlog < 8) log_addr[nlog] = rd_addr;
                nlog++;
            end else begin
                rd_valid = 1'b0;
            end
            stall = ~stall;
        end
    end

    // cfg, src, dst, ctl, next, expected src/dst/ctl of block 1
    localparam logic [31:0] VEC [0:5][0:7] = '{
        '{32'h2A, 32'h1000, 32'h2000, 32'h2008, 32'h100, 32'hA000, 32'hB000, 32'h0010},
        '{32'h15, 32'h1000, 32'h2000, 32'h2008, 32'h000, 32'h1000, 32'h2000, 32'h2008},
        '{32'h10, 32'h1000, 32'h2000, 32'h2008, 32'h000, 32'h1020, 32'h2020, 32'h2008},
        '{32'h28, 32'h1000, 32'h2000, 32'h1005, 32'h100, 32'h100A, 32'hB000, 32'h0010},
        '{32'h11, 32'h1000, 32'h2000, 32'h0003, 32'h000, 32'h1000, 32'h2003, 32'h0003},
        '{32'h00, 32'h1000, 32'h2000, 32'h1004, 32'h000, 32'h1008, 32'h2008, 32'h1004}
    };

    task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic prog(input logic [2:0] sel, input logic [DW-1:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_done();
        blk_done = 1'b1;
        @(negedge clk);
        blk_done = 1'b0;
    endtask

    task automatic wait_active();
        for (int k = 0; k < 60 && !blk_active; k++) @(negedge clk);
    endtask

    task automatic setup(input logic [31:0] cfg, input logic [31:0] s, input logic [31:0] d,
                         input logic [31:0] c, input logic [31:0] n);
        prog(3'd4, cfg); prog(3'd0, s); prog(3'd1, d); prog(3'd3, c); prog(3'd2, n);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 blk_active", DW'(blk_active), 0);
        chk("R1 xfer_done", DW'(xfer_done), 0);
        chk("R1 rd_req", DW'(rd_req), 0);

        for (int v = 0; v < 6; v++) begin
            do_reset();
            setup(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
            nlog = 0;
            pulse_start();
            // R2 block 0 shows programmed values
            chk("R2 active", DW'(blk_active), 1);
            chk("R2 src", blk_src, VEC[v][1]);
            chk("R2 dst", blk_dst, VEC[v][2]);
            chk("R2 ctl", blk_ctl, VEC[v][3]);
            if (v == 1) begin
                // R3 write while active is ignored
                prog(3'd0, 32'hDEAD_0000);
                chk("R3 src after busy write", blk_src, 32'h1000);
            end
            pulse_done();
            wait_active();
            // R5 R6 R7 R8 reloaded block
            chk($sformatf("R5/R6/R7 v%0d src", v), blk_src, VEC[v][5]);
            chk($sformatf("R5/R6/R7 v%0d dst", v), blk_dst, VEC[v][6]);
            chk($sformatf("R5/R8 v%0d ctl", v), blk_ctl, VEC[v][7]);
            if (v == 0) begin
                // R4 fetch address order
                chk("R4 beats", DW'(nlog), 4);
                for (int k = 0; k < 4; k++)
                    chk("R4 read addr", log_addr[k], 32'h100 + DW'(4 * k));
                chk("R5 next ptr", blk_next, 32'h0);
                // R9 null pointer ends the chain
                pulse_done();
                chk("R9 null ptr done", DW'(xfer_done), 1);
                chk("R9 null ptr inactive", DW'(blk_active), 0);
                @(negedge clk);
                chk("R9 done one cycle", DW'(xfer_done), 0);
            end
        end

        // R7 contiguous continues a second time
        do_reset();
        setup(32'h10, 32'h1000, 32'h2000, 32'h2008, 32'h0);
        pulse_start();
        pulse_done(); wait_active();
        pulse_done(); wait_active();
        chk("R7 third block src", blk_src, 32'h1040);

        // R9 last flag ends the chain in auto-reload mode
        do_reset();
        setup(32'h15, 32'h1000, 32'h2000, 32'h8000_2008, 32'h0);
        pulse_start();
        chk("R9 last active", DW'(blk_active), 1);
        pulse_done();
        chk("R9 last done", DW'(xfer_done), 1);
        chk("R9 last inactive", DW'(blk_active), 0);
        @(negedge clk);
        chk("R9 last pulse width", DW'(xfer_done), 0);
        chk("R9 idle stays", DW'(blk_active), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule